// File: doc/BRIEF.md
# Per-Port Frame Arrival Timestamp Latch

This block supports cable-delay measurement in a four-port node on a daisy-chained field bus. Software starts a measurement by writing to the register that holds port 0's arrival stamp. That one write arms all ports at once. When the measurement frame later reaches a port, its frame-start strobe makes the block store the low word of the free-running system time in that port's stamp register. Each port captures independently at the moment its own frame arrives.

Software then reads the four stamps and a flags word. From the differences between stamps it can work out the propagation delays between neighbouring nodes. Each port captures once per measurement. A port that sees no frame keeps its old stamp, and its valid flag reads clear, so stale data cannot be taken for a fresh arrival.

Top module: `rx_stamp_latch`

## Requirements
- R1: After reset all four stamps read zero, and the flags word reads zero (no port armed, none valid).
- R2: A write to address 0 arms every port and clears every valid flag. The flags word then reads 0x000000F0.
- R3: A write to any address other than 0 changes no stamp and no flag.
- R4: An armed port whose strobe is high in a cycle stores bits [31:0] of the system time present in that cycle. From the next cycle the port reads as valid and no longer armed.
- R5: Once a port has captured, further strobes on that port change nothing until the next arming write.
- R6: Strobes on a port that is not armed are ignored. After a re-arm, a port that receives no frame keeps its previous stamp and shows its valid flag clear.
- R7: If an arming write and a port strobe occur in the same cycle, the write wins. The strobe is not captured and the port stays armed.
- R8: Reads are combinational. Addresses 0 to 3 return the stamp of ports 0 to 3. Address 4 returns the valid flags in bits [3:0] and the armed flags in bits [7:4], bit n for port n, with other bits zero. Addresses 5 to 7 return zero.
- R9: Ports capture independently. Strobes on several ports in one cycle all store that cycle's time, and strobes in different cycles store their own cycles' times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time |
| frame_sof | input | 4 | Per-port frame-start strobe, bit n for port n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 arms a measurement) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
On every cycle the assertions check several behaviours. An arming write leaves all ports armed and none valid. A capture stores the previous cycle's low time word and sets valid. A port is never armed and valid at once. A stamp stays frozen whenever its port is not capturing. Only the bench's scenarios can show that the read map presents each stamp and flag at the right address. They also show the stale-value behaviour after a re-arm with a missing frame, and the priority of a write over a coinciding strobe as seen from the register interface.

// File: rtl/rx_stamp_latch.sv
module rx_stamp_latch #(
  parameter int NPORT = 4,
  parameter int TW    = 64,
  parameter int RW    = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    sys_time,
  input  logic [NPORT-1:0] frame_sof,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    rd_addr,
  output logic [RW-1:0]    rd_data
);
  localparam int IW = $clog2(NPORT);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NPORT);

  logic [RW-1:0]    stamp [NPORT];
  logic [NPORT-1:0] armed, valid, hit;
  logic             arm;

  assign arm = wr_en && (wr_addr == '0);
  assign hit = arm ? '0 : (armed & frame_sof);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)      stamp[i] <= '0;
      else if (hit[i]) stamp[i] <= sys_time[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= '0;
      valid <= '0;
    end else if (arm) begin
      armed <= '1;
      valid <= '0;
    end else begin
      armed <= armed & ~hit;
      valid <= valid | hit;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < FLAG_ADDR) begin
      rd_data = stamp[rd_addr[IW-1:0]];
    end else if (rd_addr == FLAG_ADDR) begin
      rd_data[NPORT-1:0]       = valid;
      rd_data[2*NPORT-1:NPORT] = armed;
    end
  end
endmodule

module rx_stamp_latch_chk #(
  parameter int NPORT = 4,
  parameter int RW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [NPORT-1:0] sof,
  input logic [RW-1:0]    tlow,
  input logic [RW-1:0]    stamp [NPORT],
  input logic [NPORT-1:0] armed,
  input logic [NPORT-1:0] valid
);
  a_r2_arm_all: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (&armed) && (valid == '0));

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R4 / R9
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (armed[i] && sof[i] && !arm) |=> (stamp[i] == $past(tlow)) && valid[i] && !armed[i]);
    // R5 / R6 / R7
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed[i] && sof[i] && !arm) |=> $stable(stamp[i]));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed[i] && valid[i]));
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && sof[i]) |=> armed[i] && !valid[i]);
  end
endmodule

bind rx_stamp_latch rx_stamp_latch_chk #(.NPORT(NPORT), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .sof(frame_sof),
  .tlow(sys_time[RW-1:0]), .stamp(stamp), .armed(armed), .valid(valid)
);

// File: tb/rx_stamp_latch_bench.sv
`timescale 1ns/1ps
module rx_stamp_latch_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] sys_time = 64'h0000_0001_FFFF_FF00;
  logic [3:0]  frame_sof = '0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_stamp_latch u_rx_stamp_latch (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .frame_sof(frame_sof),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) sys_time <= sys_time + 64'd10;

  // Reference model built from the requirements
  logic [31:0] m_stamp [4];
  logic [3:0]  m_armed, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_stamp[i] <= '0;
      m_armed <= '0;
      m_valid <= '0;
    end else if (wr_en && wr_addr == 3'd0) begin
      m_armed <= 4'hF;
      m_valid <= 4'h0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (m_armed[i] && frame_sof[i]) begin
          m_stamp[i] <= sys_time[31:0];
          m_armed[i] <= 1'b0;
          m_valid[i] <= 1'b1;
        end
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    if (a < 3'd4) return m_stamp[a[1:0]];
    if (a == 3'd4) return {24'd0, m_armed, m_valid};
    return 32'd0;
  endfunction

  task automatic step(input logic [3:0] sof, input bit wr, input logic [2:0] wa,
                      input logic [2:0] ra, input string tag);
    @(negedge clk);
    frame_sof = sof;
    wr_en     = wr;
    wr_addr   = wa;
    rd_addr   = ra;
    #1;
    checks++;
    if (rd_data !== model_rd(ra)) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, ra, rd_data, model_rd(ra));
    end
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 8; a++) step(4'h0, 0, 3'd0, 3'(a), tag);
  endtask

  task automatic expect_flags(input logic [31:0] exp, input string tag);
    step(4'h0, 0, 3'd0, 3'd4, tag);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s flags actual=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_stamp[i] = '0;
    m_armed = '0;
    m_valid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_all("R1 reset");
    expect_flags(32'h0, "R1 reset flags");

    step(4'hF, 0, 3'd0, 3'd1, "R6 unarmed strobe");
    step(4'h5, 0, 3'd0, 3'd0, "R6 unarmed strobe");
    read_all("R6 unarmed ignored");

    step(4'h0, 1, 3'd2, 3'd4, "R3 write other addr");
    step(4'h0, 1, 3'd4, 3'd4, "R3 write other addr");
    expect_flags(32'h0, "R3 no effect");

    step(4'h0, 1, 3'd0, 3'd4, "R2 arm");
    expect_flags(32'hF0, "R2 armed flags");

    step(4'h2, 0, 3'd0, 3'd1, "R4 port1 arrival");
    step(4'h0, 0, 3'd0, 3'd1, "R4 port1 read");
    step(4'h2, 0, 3'd0, 3'd1, "R5 port1 repeat");
    step(4'h0, 0, 3'd0, 3'd1, "R5 port1 unchanged");
    step(4'h9, 0, 3'd0, 3'd0, "R9 ports0,3 arrival");
    step(4'hB, 0, 3'd0, 3'd3, "R5 repeated strobes");
    read_all("R9 independent stamps");
    expect_flags(32'h4B, "R4 flags after capture");

    step(4'h0, 1, 3'd0, 3'd4, "R6 rearm");
    expect_flags(32'hF0, "R6 rearm flags");
    step(4'h1, 0, 3'd0, 3'd0, "R6 port0 only");
    read_all("R6 stale stamps kept");
    expect_flags(32'hE1, "R6 missing frames not valid");

    step(4'hF, 1, 3'd0, 3'd4, "R7 write with strobe");
    expect_flags(32'hF0, "R7 write wins");
    read_all("R7 stamps unchanged");

    step(4'hF, 0, 3'd0, 3'd2, "R9 all same cycle");
    read_all("R9 same cycle capture");
    expect_flags(32'h0F, "R9 all valid");

    for (int n = 0; n < 40; n++)
      step(4'((n * 7) % 16), (n % 9) == 0, 3'(n % 5), 3'(n % 8), "R8 mixed traffic");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule